// File: doc/BRIEF.md
# Per-Pin Power-Up Test Sequencer

This block drives the relays of a production board tester through a power-up test of every supply pin and every ground pin of the board under test. In the supply pass each step ties all ground pins to ground and powers exactly one supply pin. The block then waits a programmable settle time, samples a range flag for every monitored rail, and runs an identification request/response exchange with a helper device on the board. It then drops all relays, switches discharge loads onto every rail, and waits until the rails read as fully discharged before the next step. A second, mirrored pass follows in which the board is held at the supply level and only one ground pin is connected per step.

Every step writes one pass/fail bit into a result vector. A step passes only if all rails were in range, the helper device answered correctly, and the discharge completed before its timeout. A one-cycle done pulse follows the last ground-pin step, together with an overall pass flag. Analog measurement lives outside the block. It arrives only as comparator flags.

Top module: `pwr_seq_top`

## Requirements
- R1: In the supply pass, steps run in pin order 0 to N_SUP-1. During a step all bits of `gnd_en_o` are 1, exactly one bit of `sup_en_o` (the step's pin) is 1, and `float_en_o` is 0.
- R2: The power relays of a step are on for exactly `settle_cyc_i`+2 cycles before `id_req_o` rises. This is the settle count plus one sampling cycle.
- R3: `id_req_o` stays high until `id_ack_i` is seen. An ack with `id_ok_i`=1 passes the exchange and an ack with `id_ok_i`=0 fails it. With no ack, `id_req_o` drops after `id_tmo_i`+1 cycles and the exchange fails.
- R4: A step passes only if all `rails_ok_i` bits were 1 in the cycle before `id_req_o` rose, the exchange passed (R3), and the discharge finished in time (R5).
- R5: `dis_en_o` stays high for at least `dis_cyc_i`+2 cycles, ending at the first cycle after that minimum in which `rails_low_i` is 1. If `rails_low_i` never comes, it ends after `dis_cyc_i`+`dis_tmo_i`+2 cycles and the step fails.
- R6: Discharge is never on while any relay is on. Each change between relays and discharge passes through at least one cycle with everything off. All outputs are off after reset.
- R7: After the supply pass, ground steps run in order 0 to N_GND-1. During a ground step `float_en_o` is 1, `sup_en_o` is 0, and only that ground pin's bit of `gnd_en_o` is 1.
- R8: `result_o` bit p holds supply pin p for p < N_SUP and ground pin p-N_SUP above that. `done_o` is a one-cycle pulse after the last ground step. `all_pass_o` is the AND of all result bits from the done pulse on. Result and pass flag hold until the next start.
- R9: `start_i` clears `result_o` and begins a run from idle. It is ignored while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run when idle |
| settle_cyc_i | input | CNT_W | Settle count per step |
| dis_cyc_i | input | CNT_W | Minimum discharge count |
| dis_tmo_i | input | CNT_W | Discharge flag timeout |
| id_tmo_i | input | CNT_W | Identification response timeout |
| rails_ok_i | input | N_RAIL | Per-rail in-range comparator flags |
| rails_low_i | input | 1 | All rails below discharge threshold |
| id_ack_i | input | 1 | Helper device response strobe |
| id_ok_i | input | 1 | Response correct, valid with ack |
| gnd_en_o | output | N_GND | Ground pin relay enables |
| sup_en_o | output | N_SUP | Supply pin relay enables |
| float_en_o | output | 1 | Hold board at supply level (ground pass) |
| dis_en_o | output | 1 | Discharge loads onto all rails |
| id_req_o | output | 1 | Identification request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| result_o | output | N_SUP+N_GND | Per-pin pass bits |
| all_pass_o | output | 1 | AND of all result bits after done |

## Verification
The hardest case is a discharge whose rails-low flag arrives on the very last cycle of the timeout window. It must pass, while one cycle later it must fail. A step whose identification answer arrives in the final cycle before timeout is similarly hard. The bench's rail and helper-device model reacts to the relay and request outputs with per-step delays. Random draws pick these delays across the whole legal window, up to and including its last cycle. Directed runs with all counts at zero add the tightest windows. A start pulse issued mid-run confirms that the step sequence is not disturbed.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SAMPLE,
    ST_ID,
    ST_DEAD_A,
    ST_DISCH,
    ST_DWAIT,
    ST_DEAD_B,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (load_i)                cnt_o <= val_i;
    else if (dec_i && cnt_o != '0)  cnt_o <= cnt_o - 1'b1;
  end

  assign zero_o = (cnt_o == '0);
endmodule

// File: rtl/pwr_seq_relay.sv
module pwr_seq_relay
  import pwr_seq_pkg::*;
#(
  parameter int N_SUP = 4,
  parameter int N_GND = 3,
  parameter int IDX_W = 2
) (
  input  seq_state_e       state_i,
  input  logic             gnd_phase_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N_SUP-1:0] sup_en_o,
  output logic [N_GND-1:0] gnd_en_o,
  output logic             float_en_o,
  output logic             dis_en_o
);
  logic powered;

  assign powered    = (state_i == ST_SETTLE) || (state_i == ST_SAMPLE) || (state_i == ST_ID);
  assign float_en_o = powered && gnd_phase_i;
  assign dis_en_o   = (state_i == ST_DISCH) || (state_i == ST_DWAIT);

  for (genvar g = 0; g < N_SUP; g++) begin : g_sup
    assign sup_en_o[g] = powered && !gnd_phase_i && (idx_i == IDX_W'(g));
  end

  // supply pass: all grounds tied; ground pass: only the selected one
  for (genvar g = 0; g < N_GND; g++) begin : g_gnd
    assign gnd_en_o[g] = powered && (!gnd_phase_i || (idx_i == IDX_W'(g)));
  end
endmodule

// File: rtl/pwr_seq_log.sv
module pwr_seq_log #(
  parameter int N_PIN = 7,
  parameter int PIN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             wr_i,
  input  logic             fail_i,
  input  logic [PIN_W-1:0] idx_i,
  input  logic             val_i,
  output logic [N_PIN-1:0] result_o
);
  for (genvar p = 0; p < N_PIN; p++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              result_o[p] <= 1'b0;
      else if (clear_i)                         result_o[p] <= 1'b0;
      else if (wr_i && idx_i == PIN_W'(p))      result_o[p] <= val_i;
      else if (fail_i && idx_i == PIN_W'(p))    result_o[p] <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int N_SUP  = 4,
  parameter int N_GND  = 3,
  parameter int N_RAIL = 4,
  parameter int CNT_W  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [CNT_W-1:0]       settle_cyc_i,
  input  logic [CNT_W-1:0]       dis_cyc_i,
  input  logic [CNT_W-1:0]       dis_tmo_i,
  input  logic [CNT_W-1:0]       id_tmo_i,
  input  logic [N_RAIL-1:0]      rails_ok_i,
  input  logic                   rails_low_i,
  input  logic                   id_ack_i,
  input  logic                   id_ok_i,
  output logic [N_GND-1:0]       gnd_en_o,
  output logic [N_SUP-1:0]       sup_en_o,
  output logic                   float_en_o,
  output logic                   dis_en_o,
  output logic                   id_req_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [N_SUP+N_GND-1:0] result_o,
  output logic                   all_pass_o
);
  localparam int N_PIN = N_SUP + N_GND;
  localparam int MAXN  = (N_SUP > N_GND) ? N_SUP : N_GND;
  localparam int IDX_W = (MAXN > 1) ? $clog2(MAXN) : 1;
  localparam int PIN_W = (N_PIN > 1) ? $clog2(N_PIN) : 1;

  seq_state_e       state_q, state_d;
  logic             gnd_phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             rails_ok_q, id_pass_q, finished_q;
  logic             last_step, last_sup;
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [CNT_W-1:0] tmr_val, tmr_cnt;
  logic [PIN_W-1:0] pin_idx;
  logic             log_clear, log_wr, log_fail;

  assign last_step = gnd_phase_q && (idx_q == IDX_W'(N_GND - 1));
  assign last_sup  = !gnd_phase_q && (idx_q == IDX_W'(N_SUP - 1));
  assign pin_idx   = gnd_phase_q ? (PIN_W'(N_SUP) + PIN_W'(idx_q)) : PIN_W'(idx_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_SETTLE;
      ST_SETTLE: if (tmr_zero) state_d = ST_SAMPLE;
      ST_SAMPLE: state_d = ST_ID;
      ST_ID:     if (id_ack_i || tmr_zero) state_d = ST_DEAD_A;
      ST_DEAD_A: state_d = ST_DISCH;
      ST_DISCH:  if (tmr_zero) state_d = ST_DWAIT;
      ST_DWAIT:  if (rails_low_i || tmr_zero) state_d = ST_DEAD_B;
      ST_DEAD_B: state_d = last_step ? ST_DONE : ST_SETTLE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // one shared down-counter serves every timed phase
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = settle_cyc_i;
    unique case (state_q)
      ST_IDLE:   tmr_load = start_i;
      ST_SAMPLE: begin tmr_load = 1'b1; tmr_val = id_tmo_i;  end
      ST_DEAD_A: begin tmr_load = 1'b1; tmr_val = dis_cyc_i; end
      ST_DISCH:  begin tmr_load = tmr_zero; tmr_val = dis_tmo_i; end
      ST_DEAD_B: tmr_load = !last_step;
      default:   tmr_load = 1'b0;
    endcase
  end

  assign tmr_dec = (state_q == ST_SETTLE) || (state_q == ST_ID) ||
                   (state_q == ST_DISCH)  || (state_q == ST_DWAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      gnd_phase_q <= 1'b0;
      idx_q       <= '0;
      rails_ok_q  <= 1'b0;
      id_pass_q   <= 1'b0;
      finished_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          gnd_phase_q <= 1'b0;
          idx_q       <= '0;
          finished_q  <= 1'b0;
        end
        ST_SAMPLE: rails_ok_q <= &rails_ok_i;
        ST_ID: begin
          if (id_ack_i)      id_pass_q <= id_ok_i;
          else if (tmr_zero) id_pass_q <= 1'b0;
        end
        ST_DEAD_B: begin
          if (last_step) finished_q <= 1'b1;
          else if (last_sup) begin
            gnd_phase_q <= 1'b1;
            idx_q       <= '0;
          end else idx_q <= idx_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign log_clear = (state_q == ST_IDLE) && start_i;
  assign log_wr    = (state_q == ST_DEAD_A);
  assign log_fail  = (state_q == ST_DWAIT) && !rails_low_i && tmr_zero;

  pwr_seq_timer #(.W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .dec_i  (tmr_dec),
    .cnt_o  (tmr_cnt),
    .zero_o (tmr_zero)
  );

  pwr_seq_relay #(.N_SUP(N_SUP), .N_GND(N_GND), .IDX_W(IDX_W)) u_relay (
    .state_i     (state_q),
    .gnd_phase_i (gnd_phase_q),
    .idx_i       (idx_q),
    .sup_en_o    (sup_en_o),
    .gnd_en_o    (gnd_en_o),
    .float_en_o  (float_en_o),
    .dis_en_o    (dis_en_o)
  );

  pwr_seq_log #(.N_PIN(N_PIN), .PIN_W(PIN_W)) u_log (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (log_clear),
    .wr_i     (log_wr),
    .fail_i   (log_fail),
    .idx_i    (pin_idx),
    .val_i    (rails_ok_q && id_pass_q),
    .result_o (result_o)
  );

  assign id_req_o   = (state_q == ST_ID);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign all_pass_o = finished_q && (&result_o);
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int N_SUP = 4,
  parameter int N_GND = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SUP-1:0] sup_en_o,
  input logic [N_GND-1:0] gnd_en_o,
  input logic             float_en_o,
  input logic             dis_en_o,
  input logic             id_req_o,
  input logic             id_ack_i,
  input logic             done_o
);
  p_sup_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sup_en_o) |-> ($onehot(sup_en_o) && (&gnd_en_o) && !float_en_o));

  p_gnd_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    float_en_o |-> ($onehot(gnd_en_o) && sup_en_o == '0));

  p_no_overlap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_en_o |-> (sup_en_o == '0 && gnd_en_o == '0 && !float_en_o));

  p_dead_before_dis_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dis_en_o) |-> ($past(gnd_en_o) == '0 && $past(sup_en_o) == '0));

  p_dead_after_dis_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dis_en_o) |-> (gnd_en_o == '0 && sup_en_o == '0));

  p_req_powered_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_req_o |-> (gnd_en_o != '0));

  p_ack_ends_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_req_o && id_ack_i) |=> !id_req_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind pwr_seq_top pwr_seq_chk #(.N_SUP(N_SUP), .N_GND(N_GND)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sup_en_o   (sup_en_o),
  .gnd_en_o   (gnd_en_o),
  .float_en_o (float_en_o),
  .dis_en_o   (dis_en_o),
  .id_req_o   (id_req_o),
  .id_ack_i   (id_ack_i),
  .done_o     (done_o)
);

// File: tb/pwr_seq_top_test.sv
module pwr_seq_top_test;
  localparam int NS = 4, NG = 3, NR = 4, NP = 7, CW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, start;
  logic [CW-1:0] settle, dis, dto, idto;
  logic [NR-1:0] rails_ok;
  logic          rails_low, ack, ok;
  logic [NG-1:0] gnd_en;
  logic [NS-1:0] sup_en;
  logic          float_en, dis_en, id_req, busy, done, all_pass;
  logic [NP-1:0] result;

  pwr_seq_top #(.N_SUP(NS), .N_GND(NG), .N_RAIL(NR), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .settle_cyc_i(settle), .dis_cyc_i(dis), .dis_tmo_i(dto), .id_tmo_i(idto),
    .rails_ok_i(rails_ok), .rails_low_i(rails_low), .id_ack_i(ack), .id_ok_i(ok),
    .gnd_en_o(gnd_en), .sup_en_o(sup_en), .float_en_o(float_en), .dis_en_o(dis_en),
    .id_req_o(id_req), .busy_o(busy), .done_o(done), .result_o(result),
    .all_pass_o(all_pass)
  );

  int checks = 0, errors = 0;
  bit         cfg_rail[NP];
  logic [NR-1:0] cfg_mask[NP];
  int         cfg_id[NP];     // 0 ack ok, 1 ack bad, 2 silent
  int         cfg_iddly[NP];
  bit         cfg_dis[NP];
  int         cfg_ddly[NP];
  int k = 0, req_cnt = 0, rel_cnt = 0, dis_cnt = 0;
  bit prev_rel = 0, prev_dis = 0, prev_req = 0;

  task automatic chk(bit good, string tag, longint act, longint exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] exp_vec();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = cfg_rail[p] && cfg_id[p] == 0 && cfg_dis[p];
    return v;
  endfunction

  function automatic int exp_dis_len(int p);
    int m = int'(dis) + 2;
    if (!cfg_dis[p]) return int'(dis) + int'(dto) + 2;
    return (cfg_ddly[p] > m) ? cfg_ddly[p] : m;
  endfunction

  function automatic int exp_req_len(int p);
    return (cfg_id[p] == 2) ? int'(idto) + 1 : cfg_iddly[p];
  endfunction

  function automatic logic [NS-1:0] exp_sup(int p);
    return (p < NS) ? NS'(1) << p : '0;
  endfunction

  function automatic logic [NG-1:0] exp_gnd(int p);
    return (p < NS) ? '1 : NG'(1) << (p - NS);
  endfunction

  // board and helper-device model
  always @(negedge clk) begin
    if (rst_n) begin
      bit rel;
      string tg;
      rel = (|sup_en) || (|gnd_en);
      if (k < NP) rails_ok <= cfg_rail[k] ? '1 : cfg_mask[k];
      if (!rel) rel_cnt = 0;
      else if (!id_req) rel_cnt++;
      if (id_req && !prev_req && k < NP) begin
        chk(rel_cnt == int'(settle) + 2, "R2 settle", rel_cnt, int'(settle) + 2);
        tg = (k < NS) ? "R1 relays" : "R7 relays";
        chk(sup_en == exp_sup(k) && gnd_en == exp_gnd(k) && float_en == (k >= NS),
            tg, {float_en, sup_en, gnd_en}, {1'b0 + (k >= NS), exp_sup(k), exp_gnd(k)});
      end
      if (id_req) begin
        req_cnt++;
        if (k < NP && cfg_id[k] != 2 && req_cnt == cfg_iddly[k]) begin
          ack <= 1'b1;
          ok  <= (cfg_id[k] == 0);
        end else begin
          ack <= 1'b0;
          ok  <= ($urandom % 2) == 1;
        end
      end else ack <= 1'b0;
      if (!id_req && prev_req) begin
        if (k < NP) chk(req_cnt == exp_req_len(k), "R3 req length", req_cnt, exp_req_len(k));
        req_cnt = 0;
      end
      if (dis_en) begin
        dis_cnt++;
        rails_low <= (k < NP) && cfg_dis[k] && dis_cnt >= cfg_ddly[k];
      end else rails_low <= 1'b0;
      if (dis_en && !prev_dis) chk(!prev_rel, "R6 dead before discharge", prev_rel, 0);
      if (rel && !prev_rel)    chk(!prev_dis, "R6 dead after discharge", prev_dis, 0);
      if (!dis_en && prev_dis) begin
        if (k < NP) chk(dis_cnt == exp_dis_len(k), "R5 discharge length", dis_cnt, exp_dis_len(k));
        dis_cnt = 0;
        k++;
      end
      prev_rel = rel;
      prev_dis = dis_en;
      prev_req = id_req;
    end
  end

  task automatic set_params(int s, int d, int t, int i);
    settle = CW'(s); dis = CW'(d); dto = CW'(t); idto = CW'(i);
  endtask

  task automatic cfg_pass();
    for (int p = 0; p < NP; p++) begin
      cfg_rail[p] = 1; cfg_mask[p] = '1; cfg_id[p] = 0; cfg_iddly[p] = 1;
      cfg_dis[p] = 1; cfg_ddly[p] = 1;
    end
  endtask

  task automatic cfg_random();
    for (int p = 0; p < NP; p++) begin
      int m;
      cfg_rail[p]  = ($urandom % 4) != 0;
      cfg_mask[p]  = NR'($urandom) & ~(NR'(1) << ($urandom % NR));
      m            = $urandom % 4;
      cfg_id[p]    = (m == 3) ? 0 : m;
      cfg_iddly[p] = 1 + ($urandom % (int'(idto) + 1));
      cfg_dis[p]   = ($urandom % 4) != 0;
      cfg_ddly[p]  = 1 + ($urandom % (int'(dis) + int'(dto) + 2));
    end
    // pin the last-cycle windows on two steps
    cfg_iddly[0] = int'(idto) + 1; cfg_id[0] = 0;
    cfg_ddly[1]  = int'(dis) + int'(dto) + 2; cfg_dis[1] = 1;
  endtask

  task automatic run(bit poke_start);
    logic [NP-1:0] ev, held;
    int cyc = 0;
    ev = exp_vec();
    k = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(result == '0 && busy, "R9 start clears result", result, 0);
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (poke_start) start = (cyc == 15 || cyc == 40);
    end
    start = 1'b0;
    chk(result == ev, "R4 result vector", result, ev);
    chk(all_pass == (&ev), "R8 all pass", all_pass, &ev);
    chk(k == NP, poke_start ? "R9 steps with start while busy" : "R8 step count", k, NP);
    held = result;
    @(negedge clk);
    chk(!done && !busy, "R8 done pulse width", done, 0);
    repeat (3) @(negedge clk);
    chk(result == held && all_pass == (&ev), "R8 result held", result, held);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0; ack = 1'b0; ok = 1'b0; rails_low = 1'b0; rails_ok = '0;
    set_params(3, 2, 5, 4);
    cfg_pass();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sup_en == '0 && gnd_en == '0 && !float_en && !dis_en && !id_req,
        "R6 reset outputs", {sup_en, gnd_en, dis_en}, 0);
    chk(!busy && !done && result == '0 && !all_pass, "R8 reset status", result, 0);

    run(1'b0);                         // all steps pass
    set_params(0, 0, 0, 0);
    cfg_random();
    run(1'b0);                         // zero-count corners
    set_params(2, 3, 4, 3);
    cfg_pass();
    cfg_id[2] = 2; cfg_dis[5] = 0; cfg_rail[6] = 0; cfg_mask[6] = 4'b1011; cfg_id[4] = 1;
    run(1'b1);                         // directed failures, start pokes while busy
    for (int r = 0; r < 6; r++) begin
      set_params($urandom % 6, $urandom % 5, $urandom % 6, $urandom % 5);
      cfg_random();
      run(r == 3);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule